// File: doc/BRIEF.md
# Auto-Reload Interval Timer with Sticky Interrupt

This block is a periodic interval timer for a host-controlled peripheral. A 6-bit down-counter advances once per prescale tick. When a tick arrives while the counter already holds zero, the timer expires. On that same edge it reloads itself from a host-programmed value and keeps running with no host action. The period is therefore the reload value plus one ticks.

Each expiry sets a sticky status flag. The host clears the flag by writing a one to it. An enable flag decides whether the status reaches the active-low interrupt output, and that output is registered.

A hard reset clears everything. A soft reset only reloads the counter. A stop input freezes counting. Neither the soft reset nor stop touches the status or enable flags.

The host sees three words through a simple write port and a combinational read port:
- Address 0 holds the reload value.
- Address 1 holds control and status: bit 0 is status, bit 1 is enable.
- Address 2 returns the live count.

Top module: `swt_top`

## Requirements
- R1: On a clock edge with `tick`=1, `stop`=0 and `soft_rst`=0, a nonzero count decreases by exactly one. With `tick`=0 the count does not change.
- R2: On a clock edge with `tick`=1, `stop`=0, `soft_rst`=0 and count zero, the timer expires and loads the reload value that was held before that edge, so the period is reload+1 ticks.
- R3: An expiry sets the status flag (address 1, bit 0) on the same edge. The status is never set without an expiry.
- R4: A write to address 1 with bit 0 = 1 clears the status. A write to address 1 with bit 0 = 0 leaves the status unchanged.
- R5: When an expiry and a status-clearing write happen on the same edge, the status ends at 1.
- R6: `irq_n` is 0 exactly when status and enable were both 1 one cycle earlier. It is registered, so it lags a change of either flag by one edge.
- R7: Hard reset (`rst_n`=0, asynchronous) sets status=0, enable=0, `irq_n`=1, reload=63 and count=63.
- R8: `soft_rst`=1 loads the count from the reload value, causes no expiry on that edge, and leaves status and enable unchanged.
- R9: `stop`=1 holds the count and ignores ticks. Status and enable stay unchanged, and host writes to the registers still take effect.
- R10: With a reload value of 0, every qualifying tick is an expiry and sets the status.
- R11: Register map:
  - Address 0, bits 5:0 read and write the reload value. A new reload value takes effect only at the next reload.
  - Address 1, bit 1 is enable.
  - Address 2 reads the count. Writes to address 2 or 3 are ignored.
  - Unused read bits, and every bit read at address 3, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset: reloads the counter only |
| stop | input | 1 | Freezes the counter while high |
| tick | input | 1 | One-cycle prescale pulse that advances the counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq_n | output | 1 | Registered interrupt, active low |

## Verification
On every cycle, the assertions check the following:
- the one-step decrement;
- the reload from the previously held value at zero;
- the status being set by an expiry and only by an expiry;
- the clearing write;
- the one-cycle lag of `irq_n`;
- the counter load on soft reset;
- the count freeze under stop.

Some behaviours are visible only through the bench's scenarios, because they span several edges or involve the register port:
- the full reload+1 period;
- the set-wins outcome when a clear and an expiry coincide;
- flags surviving a soft reset or stop while the host rewrites the registers;
- a zero reload expiring on every tick;
- an asynchronous hard reset in the middle of a run.

// File: rtl/swt_pkg.sv
package swt_pkg;
    localparam int unsigned A_RELOAD = 0;
    localparam int unsigned A_CTRL   = 1;
    localparam int unsigned A_COUNT  = 2;
    localparam int unsigned B_STATUS = 0;
    localparam int unsigned B_ENABLE = 1;

    typedef struct packed {
        logic status;
        logic enable;
        logic irq_n;
    } intr_t;
endpackage

// File: rtl/swt_counter.sv
module swt_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] CNT_RST = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (soft_rst) begin
            cnt_d.cnt = reload;
        end else if (tick && !stop) begin
            if (cnt_q.cnt == '0) begin
                cnt_d.cnt = reload;
                expire    = 1'b1;
            end else begin
                cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '{cnt: CNT_RST};
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;
endmodule

// File: rtl/swt_intr.sv
module swt_intr
    import swt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_req,
    input  logic en_we,
    input  logic en_wdata,
    output logic status,
    output logic enable,
    output logic irq_n
);
    intr_t intr_d, intr_q;

    always_comb begin
        intr_d       = intr_q;
        intr_d.irq_n = !(intr_q.status && intr_q.enable);
        if (en_we)   intr_d.enable = en_wdata;
        if (clr_req) intr_d.status = 1'b0;
        if (expire)  intr_d.status = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) intr_q <= '{status: 1'b0, enable: 1'b0, irq_n: 1'b1};
        else        intr_q <= intr_d;
    end

    assign status = intr_q.status;
    assign enable = intr_q.enable;
    assign irq_n  = intr_q.irq_n;
endmodule

// File: rtl/swt_regs.sv
module swt_regs
    import swt_pkg::*;
#(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              status,
    input  logic              enable,
    output logic [CNT_W-1:0]  reload,
    output logic              clr_req,
    output logic              en_we,
    output logic              en_wdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    logic wr_reload, wr_ctrl;

    always_comb begin
        wr_reload = wr_en && (wr_addr == ADDR_W'(A_RELOAD));
        wr_ctrl   = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        clr_req   = wr_ctrl && wr_data[B_STATUS];
        en_we     = wr_ctrl;
        en_wdata  = wr_data[B_ENABLE];
        regs_d    = regs_q;
        if (wr_reload) regs_d.reload = wr_data[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{reload: RELOAD_RST};
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_RELOAD)) begin
            rd_data[CNT_W-1:0] = regs_q.reload;
        end else if (rd_addr == ADDR_W'(A_CTRL)) begin
            rd_data[B_STATUS] = status;
            rd_data[B_ENABLE] = enable;
        end else if (rd_addr == ADDR_W'(A_COUNT)) begin
            rd_data[CNT_W-1:0] = count;
        end
    end

    generate
        if (DATA_W > CNT_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_data[DATA_W-1:CNT_W];
        end
    endgenerate

    assign reload = regs_q.reload;
endmodule

// File: rtl/swt_top.sv
module swt_top #(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] count_w;
    logic             expire_w;
    logic             clr_w;
    logic             en_we_w;
    logic             en_wd_w;
    logic             status_w;
    logic             enable_w;

    swt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .count    (count_w),
        .status   (status_w),
        .enable   (enable_w),
        .reload   (reload_w),
        .clr_req  (clr_w),
        .en_we    (en_we_w),
        .en_wdata (en_wd_w),
        .rd_data  (rd_data)
    );

    swt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .stop     (stop),
        .tick     (tick),
        .reload   (reload_w),
        .count    (count_w),
        .expire   (expire_w)
    );

    swt_intr u_intr (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire_w),
        .clr_req  (clr_w),
        .en_we    (en_we_w),
        .en_wdata (en_wd_w),
        .status   (status_w),
        .enable   (enable_w),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/swt_checker.sv
module swt_checker
    import swt_pkg::*;
#(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              stop,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_bit0,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  count,
    input logic              status,
    input logic              enable,
    input logic              irq_n
);
    logic run, zero, clr1;
    assign run  = tick && !stop && !soft_rst;
    assign zero = (count == '0);
    assign clr1 = wr_en && (wr_addr == ADDR_W'(A_CTRL)) && wr_bit0;

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        run && !zero |=> count == ($past(count) - CNT_W'(1))); // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !soft_rst |=> $stable(count)); // R1
    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run && zero |=> count == $past(reload)); // R2
    AST_EXPIRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        run && zero |=> status); // R3
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !status && !(run && zero) |=> !status); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status && !clr1 |=> status); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        clr1 && !(run && zero) |=> !status); // R4
    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_n == !$past(status && enable)); // R6
    AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> count == $past(reload)); // R8
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !soft_rst |=> $stable(count)); // R9
endmodule

bind swt_top swt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .stop     (stop),
    .tick     (tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_bit0  (wr_data[0]),
    .reload   (reload_w),
    .count    (count_w),
    .status   (status_w),
    .enable   (enable_w),
    .irq_n    (irq_n)
);

// File: tb/swt_top_test.sv
`timescale 1ns/1ps
module swt_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0, stop = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk = 0, n_fail = 0;
    logic [5:0] m_cnt, m_rel;
    logic       m_st, m_en, m_irqn;

    always #2.5 clk = ~clk;

    swt_top uut (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
                 .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                 .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n));

    function automatic logic [5:0] f_cnt(logic [5:0] c, logic [5:0] r,
                                         logic sr, logic sp, logic tk);
        if (sr) return r;
        if (tk && !sp) return (c == 6'd0) ? r : c - 6'd1;
        return c;
    endfunction

    function automatic logic f_expire(logic [5:0] c, logic sr, logic sp, logic tk);
        return tk && !sp && !sr && (c == 6'd0);
    endfunction

    function automatic logic [7:0] f_read(logic [1:0] a);
        case (a)
            2'd0: return {2'b00, m_rel};
            2'd1: return {6'b0, m_en, m_st};
            2'd2: return {2'b00, m_cnt};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 6'd63; m_rel = 6'd63; m_st = 1'b0; m_en = 1'b0; m_irqn = 1'b1;
    endtask

    task automatic cyc();
        logic ex;
        @(posedge clk);
        if (rst_n) begin
            ex     = f_expire(m_cnt, soft_rst, stop, tick);
            m_irqn = !(m_st && m_en);
            m_cnt  = f_cnt(m_cnt, m_rel, soft_rst, stop, tick);
            if (wr_en && wr_addr == 2'd1) begin
                m_en = wr_data[1];
                if (wr_data[0]) m_st = 1'b0;
            end
            if (ex) m_st = 1'b1;
            if (wr_en && wr_addr == 2'd0) m_rel = wr_data[5:0];
        end
        @(negedge clk);
    endtask

    task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk(string tag);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.2;
            cmp(tag, $sformatf("rd[%0d]", a), rd_data, f_read(2'(a)));
        end
        cmp(tag, "irq_n", {7'b0, irq_n}, {7'b0, m_irqn});
    endtask

    task automatic drive(logic tk, logic sp, logic sr, logic we, logic [1:0] a, logic [7:0] d);
        tick = tk; stop = sp; soft_rst = sr; wr_en = we; wr_addr = a; wr_data = d;
        cyc();
        tick = 0; stop = 0; soft_rst = 0; wr_en = 0;
    endtask

    task automatic hard_reset();
        rst_n = 1'b0;
        model_reset();
        cyc(); cyc();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        hard_reset();
        chk("R7 reset state");

        drive(0, 0, 0, 1, 2'd0, 8'd3);          chk("R11 reload write");
        drive(0, 0, 0, 1, 2'd1, 8'h02);         chk("R11 enable write");
        drive(0, 0, 0, 0, 2'd0, 8'd0);          chk("R1 no tick holds");
        drive(0, 0, 1, 0, 2'd0, 8'd0);          chk("R8 soft load");
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 0, 0, 2'd0, 8'd0);      chk("R1 decrement");
        end
        drive(1, 0, 0, 0, 2'd0, 8'd0);          chk("R2 R3 expiry reload");
        drive(0, 0, 0, 0, 2'd0, 8'd0);          chk("R6 irq lag");
        drive(0, 0, 0, 1, 2'd1, 8'h02);         chk("R4 write zero keeps");
        drive(0, 0, 0, 1, 2'd1, 8'h03);         chk("R4 w1c");
        drive(0, 0, 0, 0, 2'd0, 8'd0);          chk("R6 irq release");

        drive(0, 0, 0, 1, 2'd0, 8'd0);          chk("R11 reload zero");
        drive(0, 0, 1, 0, 2'd0, 8'd0);          chk("R8 soft load zero");
        drive(1, 0, 0, 1, 2'd1, 8'h03);         chk("R5 set wins over clear");
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 0, 1, 2'd1, 8'h03);     chk("R10 clear");
            drive(1, 0, 0, 0, 2'd0, 8'd0);      chk("R10 expire every tick");
        end

        drive(0, 0, 0, 1, 2'd0, 8'd9);          chk("R11 reload later");
        drive(1, 0, 0, 0, 2'd0, 8'd0);          chk("R2 uses new reload");
        for (int i = 0; i < 3; i++) begin
            drive(1, 1, 0, 0, 2'd0, 8'd0);      chk("R9 stop holds");
        end
        drive(1, 1, 0, 1, 2'd0, 8'd5);          chk("R9 write under stop");
        drive(0, 1, 0, 1, 2'd1, 8'h00);         chk("R9 enable write under stop");
        drive(0, 0, 0, 1, 2'd1, 8'h02);         chk("R9 enable back");
        drive(1, 0, 1, 0, 2'd0, 8'd0);          chk("R8 soft keeps flags");
        drive(0, 0, 0, 1, 2'd2, 8'h11);         chk("R11 count write ignored");
        drive(0, 0, 0, 1, 2'd3, 8'hFF);         chk("R11 addr3 ignored");

        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom % 4);
            d = (a == 2'd0) ? 8'($urandom % 8) : 8'($urandom);
            if ($urandom % 600 == 0) begin
                hard_reset();
                chk("R7 random reset");
            end
            drive(($urandom % 2) == 0, ($urandom % 10) == 0, ($urandom % 30) == 0,
                  ($urandom % 7) == 0, a, d);
            chk("R1 R2 R3 R4 R5 R6 R8 R9 random");
        end
        finish_run();
    end
endmodule